// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Registers

This block holds the type-0 configuration header of a PCI function. Identity fields, bus-master behaviour, base-address layout and error masking are all fixed by build-time parameters. A configuration access arrives as a single-cycle request carrying a dword index, per-byte enables and write data. A read returns its dword one cycle later with a valid strobe.

The header provides three base-address areas. Each area is built as two independent 32-bit BARs, as one 64-bit memory BAR, or is left unused. A BAR hardwires its low address bits according to its size. Writing all ones and reading back therefore yields the size mask together with the fixed type bits. Six status error bits are set by single-cycle event inputs and cleared by software writing 1. The error bits selected by a mask are ORed onto one summary output.

Top module: `pci_cfg_hdr`

## Requirements
- R1: Dword 0 reads {DEVICE_ID, VENDOR_ID} and dword 2 reads {CLASS_CODE[23:0], REV_ID[7:0]}. Writes to either dword leave them unchanged.
- R2: A read request (req=1, we=0) drives cfg_rdata_o and rd_valid_o=1 in the following cycle. rd_valid_o is 0 in every other cycle. Dwords 10 and above read 0 and ignore writes.
- R3: Command bit 2 (dword 1, byte 0) is the bus-master enable and drives bus_master_o. In mode BM_TARGET it is read-only 0. In mode BM_BOTH it resets to 0 and is writable. In mode BM_MASTER it is read-only 1.
- R4: The latency timer is dword 3 bits 15:8. It resets to LAT_INIT, bits 10:8 always read 0, and bits 15:11 are writable through byte 1.
- R5: A 32-bit BAR keeps only address bits at or above its size log2, and the bits below it read 0. An I/O BAR reads bit 0 as 1. A memory BAR reads bits 2:1 as 00 and bit 3 as its prefetchable flag.
- R6: A 64-bit area is one memory BAR. Its low dword reads bits 2:1 as 10 and bit 3 as prefetch. Its high dword holds address bits 63:32, with bits below the size log2 forced to 0.
- R7: In an unused area both dwords read 0 and ignore writes.
- R8: Each write byte lane updates its register byte only when the matching cfg_be_i bit is 1.
- R9: err_evt_i[0..5] set status bits 8, 11, 12, 13, 14 and 15 (dword 1 bits 24, 27, 28, 29, 30, 31). Writing 1 to such a bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clear leaves the bit set.
- R10: err_any_o is the OR of the status error bits ANDed with ERR_MASK, where mask bit k gates err_evt_i[k]'s bit. It reflects a bit in the cycle after the bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_req_i | input | 1 | Access request, one cycle |
| cfg_we_i | input | 1 | 1 = write, 0 = read |
| cfg_addr_i | input | 6 | Dword index into the header |
| cfg_be_i | input | 4 | Byte enables for writes |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data, registered |
| rd_valid_o | output | 1 | Read data valid |
| err_evt_i | input | 6 | Error event pulses |
| bus_master_o | output | 1 | Bus-master enable |
| err_any_o | output | 1 | Masked OR of status error bits |

## Verification
The main instance has area 0 as an I/O BAR of 2^8 bytes next to a prefetchable memory BAR of 2^12 bytes. Area 1 is a prefetchable 64-bit BAR of 2^36 bytes, which puts the size boundary in the high dword, and area 2 is left unused. The bus-master mode is BM_BOTH and ERR_MASK is 6'b101101, so both a masked-in and a masked-out error bit can be observed. Two extra instances built with BM_TARGET and BM_MASTER receive the same writes, so all three bus-master modes are checked in one run.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  typedef enum logic [1:0] {BM_TARGET = 2'd0, BM_BOTH = 2'd1, BM_MASTER = 2'd2} bm_mode_e;
  typedef enum logic [1:0] {AREA_NONE = 2'd0, AREA_TWO32 = 2'd1, AREA_ONE64 = 2'd2} area_kind_e;

  localparam int unsigned N_AREA = 3;
  localparam int unsigned N_ERR  = 6;
  localparam int unsigned LGW    = 7;

  function automatic logic [63:0] size_mask(int unsigned lg);
    if (lg >= 64) return 64'h0;
    return ~64'h0 << lg;
  endfunction
endpackage

// File: rtl/pci_cfg_bar_area.sv
module pci_cfg_bar_area
  import pci_cfg_pkg::*;
#(
  parameter area_kind_e  KIND    = AREA_NONE,
  parameter int unsigned LOG2_LO = 4,
  parameter bit          IO_LO   = 1'b0,
  parameter bit          PREF_LO = 1'b0,
  parameter int unsigned LOG2_HI = 4,
  parameter bit          IO_HI   = 1'b0,
  parameter bit          PREF_HI = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rd_lo_o,
  output logic [31:0] rd_hi_o
);
  localparam logic [63:0] M_LO64 = size_mask(LOG2_LO);
  localparam logic [63:0] M_HI64 = size_mask(LOG2_HI);
  localparam logic [31:0] MSK_LO = (KIND == AREA_NONE) ? 32'h0 : M_LO64[31:0];
  localparam logic [31:0] MSK_HI = (KIND == AREA_NONE)  ? 32'h0 :
                                   (KIND == AREA_ONE64) ? M_LO64[63:32] : M_HI64[31:0];
  localparam logic [31:0] TYP_LO = (KIND == AREA_NONE)  ? 32'h0 :
                                   (KIND == AREA_ONE64) ? {28'h0, PREF_LO, 3'b100} :
                                   IO_LO ? 32'h1 : {28'h0, PREF_LO, 3'b000};
  localparam logic [31:0] TYP_HI = (KIND != AREA_TWO32) ? 32'h0 :
                                   IO_HI ? 32'h1 : {28'h0, PREF_HI, 3'b000};

  logic [31:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      for (int b = 0; b < 4; b++) begin
        if (wr_lo_i && be_i[b]) lo_q[b*8 +: 8] <= wdata_i[b*8 +: 8] & MSK_LO[b*8 +: 8];
        if (wr_hi_i && be_i[b]) hi_q[b*8 +: 8] <= wdata_i[b*8 +: 8] & MSK_HI[b*8 +: 8];
      end
    end
  end

  assign rd_lo_o = (lo_q & MSK_LO) | TYP_LO;
  assign rd_hi_o = (hi_q & MSK_HI) | TYP_HI;

  if (KIND == AREA_NONE) begin : g_unused
    // R7
    unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_lo_o == 32'h0) && (rd_hi_o == 32'h0));
  end
endmodule

// File: rtl/pci_cfg_err.sv
module pci_cfg_err
  import pci_cfg_pkg::*;
#(
  parameter logic [N_ERR-1:0] MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ERR-1:0] evt_i,
  input  logic [N_ERR-1:0] clr_i,
  output logic [N_ERR-1:0] err_o,
  output logic             any_o
);
  logic [N_ERR-1:0] err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= '0;
    else         err_q <= (err_q & ~clr_i) | evt_i;  // set beats clear
  end

  assign err_o = err_q;
  assign any_o = |(err_q & MASK);

  for (genvar k = 0; k < N_ERR; k++) begin : g_chk
    // R9
    evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[k] |=> err_o[k]);
    // R9
    clr_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !evt_i[k]) |=> !err_o[k]);
  end
endmodule

// File: rtl/pci_cfg_hdr.sv
module pci_cfg_hdr
  import pci_cfg_pkg::*;
#(
  parameter logic [15:0]        VENDOR_ID  = 16'h1234,
  parameter logic [15:0]        DEVICE_ID  = 16'h5678,
  parameter logic [7:0]         REV_ID     = 8'h01,
  parameter logic [23:0]        CLASS_CODE = 24'h020000,
  parameter bm_mode_e           BM_MODE    = BM_BOTH,
  parameter logic [N_ERR-1:0]   ERR_MASK   = '1,
  parameter logic [7:0]         LAT_INIT   = 8'h20,
  parameter logic [2*N_AREA-1:0] AREA_KIND = {2'd0, 2'd2, 2'd1},
  parameter logic [LGW*2*N_AREA-1:0] BAR_LOG2 = {7'd4, 7'd4, 7'd4, 7'd20, 7'd12, 7'd8},
  parameter logic [2*N_AREA-1:0] BAR_IO    = 6'b000001,
  parameter logic [2*N_AREA-1:0] BAR_PREF  = 6'b000010
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_req_i,
  input  logic             cfg_we_i,
  input  logic [5:0]       cfg_addr_i,
  input  logic [3:0]       cfg_be_i,
  input  logic [31:0]      cfg_wdata_i,
  output logic [31:0]      cfg_rdata_o,
  output logic             rd_valid_o,
  input  logic [N_ERR-1:0] err_evt_i,
  output logic             bus_master_o,
  output logic             err_any_o
);
  localparam int unsigned BAR_BASE = 4;

  logic wr;
  assign wr = cfg_req_i && cfg_we_i;

  // bus-master enable
  logic bm_q;
  if (BM_MODE == BM_BOTH) begin : g_bm_rw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bm_q <= 1'b0;
      else if (wr && cfg_addr_i == 6'd1 && cfg_be_i[0]) bm_q <= cfg_wdata_i[2];
    end
  end else begin : g_bm_ro
    assign bm_q = (BM_MODE == BM_MASTER);
  end
  assign bus_master_o = bm_q;

  // latency timer, low three bits hardwired
  logic [4:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= LAT_INIT[7:3];
    else if (wr && cfg_addr_i == 6'd3 && cfg_be_i[1]) lat_q <= cfg_wdata_i[15:11];
  end

  // status error bits, all in byte 3 of dword 1
  logic [N_ERR-1:0] err, err_clr;
  logic             st_wr;
  assign st_wr   = wr && cfg_addr_i == 6'd1 && cfg_be_i[3];
  assign err_clr = st_wr ? {cfg_wdata_i[31:27], cfg_wdata_i[24]} : '0;

  pci_cfg_err #(.MASK(ERR_MASK)) u_err (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (err_evt_i),
    .clr_i (err_clr),
    .err_o (err),
    .any_o (err_any_o)
  );

  // BAR areas
  logic [31:0] bar_lo [N_AREA];
  logic [31:0] bar_hi [N_AREA];

  for (genvar a = 0; a < N_AREA; a++) begin : g_area
    localparam logic [5:0] A_LO = 6'(BAR_BASE + 2*a);
    localparam logic [5:0] A_HI = 6'(BAR_BASE + 2*a + 1);
    pci_cfg_bar_area #(
      .KIND   (area_kind_e'(AREA_KIND[2*a +: 2])),
      .LOG2_LO(int'(BAR_LOG2[LGW*(2*a) +: LGW])),
      .IO_LO  (BAR_IO[2*a]),
      .PREF_LO(BAR_PREF[2*a]),
      .LOG2_HI(int'(BAR_LOG2[LGW*(2*a+1) +: LGW])),
      .IO_HI  (BAR_IO[2*a+1]),
      .PREF_HI(BAR_PREF[2*a+1])
    ) u_area (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_lo_i(wr && cfg_addr_i == A_LO),
      .wr_hi_i(wr && cfg_addr_i == A_HI),
      .be_i   (cfg_be_i),
      .wdata_i(cfg_wdata_i),
      .rd_lo_o(bar_lo[a]),
      .rd_hi_o(bar_hi[a])
    );
  end

  // read mux
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (cfg_addr_i)
      6'd0: rd_mux = {DEVICE_ID, VENDOR_ID};
      6'd1: rd_mux = {err[5:1], 2'b00, err[0], 8'h00, 13'h0, bm_q, 2'b00};
      6'd2: rd_mux = {CLASS_CODE, REV_ID};
      6'd3: rd_mux = {16'h0, lat_q, 3'b000, 8'h00};
      6'd4: rd_mux = bar_lo[0];
      6'd5: rd_mux = bar_hi[0];
      6'd6: rd_mux = bar_lo[1];
      6'd7: rd_mux = bar_hi[1];
      6'd8: rd_mux = bar_lo[2];
      6'd9: rd_mux = bar_hi[2];
      default: rd_mux = '0;
    endcase
  end

  logic [31:0] rdata_q;
  logic        rvld_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      rvld_q  <= 1'b0;
    end else begin
      rvld_q <= cfg_req_i && !cfg_we_i;
      if (cfg_req_i && !cfg_we_i) rdata_q <= rd_mux;
    end
  end
  assign cfg_rdata_o = rdata_q;
  assign rd_valid_o  = rvld_q;

  // R2
  rd_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_i && !cfg_we_i) |=> rd_valid_o);
  // R2
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_req_i && !cfg_we_i) |=> !rd_valid_o);
  // R3
  bm_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (BM_MODE == BM_MASTER) ? bus_master_o : ((BM_MODE == BM_TARGET) ? !bus_master_o : 1'b1));
  // R4
  lat_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_i && !cfg_we_i && cfg_addr_i == 6'd3) |=> (cfg_rdata_o[10:8] == 3'b000));
endmodule

// File: tb/pci_cfg_hdr_bench.sv
module pci_cfg_hdr_bench;
  import pci_cfg_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [5:0]  evt = '0;
  logic [31:0] rdata, rdata_t, rdata_m;
  logic        rvld, rvld_t, rvld_m;
  logic        bm, bm_t, bm_m;
  logic        any, any_t, any_m;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #10 clk = ~clk;  // 50 MHz

  localparam logic [LGW*6-1:0] LG = {7'd4, 7'd4, 7'd4, 7'd36, 7'd12, 7'd8};

  pci_cfg_hdr #(
    .VENDOR_ID(16'h1A2B), .DEVICE_ID(16'h3C4D), .REV_ID(8'h5E), .CLASS_CODE(24'h0C0330),
    .BM_MODE(BM_BOTH), .ERR_MASK(6'b101101), .LAT_INIT(8'h40),
    .AREA_KIND({2'd0, 2'd2, 2'd1}), .BAR_LOG2(LG), .BAR_IO(6'b000001), .BAR_PREF(6'b000110)
  ) u_pci_cfg_hdr (
    .clk_i(clk), .rst_ni(rst_n), .cfg_req_i(req), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_be_i(be), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .rd_valid_o(rvld),
    .err_evt_i(evt), .bus_master_o(bm), .err_any_o(any)
  );

  pci_cfg_hdr #(.BM_MODE(BM_TARGET)) u_tgt (
    .clk_i(clk), .rst_ni(rst_n), .cfg_req_i(req), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_be_i(be), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata_t), .rd_valid_o(rvld_t),
    .err_evt_i(evt), .bus_master_o(bm_t), .err_any_o(any_t)
  );

  pci_cfg_hdr #(.BM_MODE(BM_MASTER)) u_mst (
    .clk_i(clk), .rst_ni(rst_n), .cfg_req_i(req), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_be_i(be), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata_m), .rd_valid_o(rvld_m),
    .err_evt_i(evt), .bus_master_o(bm_m), .err_any_o(any_m)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [5:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; be = b; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  // driver: push expectation, monitor pops it one cycle later
  task automatic cfg_rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; be = 4'h0;
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic pulse_evt(input logic [5:0] e);
    @(negedge clk);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rvld) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R2 unexpected rd_valid", rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check(rdata === e, t, rdata, e);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(rvld == 1'b0, "R2 reset rd_valid", {31'h0, rvld}, 32'h0);
    check(bm == 1'b0, "R3 reset both-mode bm", {31'h0, bm}, 32'h0);
    check(any == 1'b0, "R10 reset err_any", {31'h0, any}, 32'h0);

    // R1 identity
    cfg_rd(6'd0, 32'h3C4D1A2B, "R1 ids");
    cfg_rd(6'd2, 32'h0C03305E, "R1 class/rev");
    cfg_wr(6'd0, 4'hF, 32'h0);
    cfg_wr(6'd2, 4'hF, 32'hFFFFFFFF);
    cfg_rd(6'd0, 32'h3C4D1A2B, "R1 ids after write");
    cfg_rd(6'd2, 32'h0C03305E, "R1 class/rev after write");

    // R2 unimplemented
    cfg_wr(6'd20, 4'hF, 32'hDEADBEEF);
    cfg_rd(6'd20, 32'h0, "R2 unimplemented");
    cfg_rd(6'd63, 32'h0, "R2 top dword");

    // R4 latency timer
    cfg_rd(6'd3, 32'h00004000, "R4 lat reset");
    cfg_wr(6'd3, 4'hF, 32'hFFFFFFFF);
    cfg_rd(6'd3, 32'h0000F800, "R4 lat all ones");
    cfg_wr(6'd3, 4'b1101, 32'h0);
    cfg_rd(6'd3, 32'h0000F800, "R8 lat byte1 disabled");

    // R8 byte lanes on I/O BAR
    cfg_rd(6'd4, 32'h00000001, "R5 io bar reset");
    cfg_wr(6'd4, 4'b0010, 32'hAABBCCDD);
    cfg_rd(6'd4, 32'h0000CC01, "R8 io bar byte1");
    // R5 sizing
    cfg_wr(6'd4, 4'hF, 32'hFFFFFFFF);
    cfg_rd(6'd4, 32'hFFFFFF01, "R5 io size 2^8");
    cfg_wr(6'd5, 4'hF, 32'hFFFFFFFF);
    cfg_rd(6'd5, 32'hFFFFF008, "R5 mem pref size 2^12");
    cfg_wr(6'd5, 4'b0001, 32'h0);
    cfg_rd(6'd5, 32'hFFFFF008, "R8 mem byte0 below size");

    // R6 64-bit BAR
    cfg_rd(6'd6, 32'h0000000C, "R6 lo reset");
    cfg_wr(6'd6, 4'hF, 32'hFFFFFFFF);
    cfg_wr(6'd7, 4'hF, 32'hFFFFFFFF);
    cfg_rd(6'd6, 32'h0000000C, "R6 lo all ones");
    cfg_rd(6'd7, 32'hFFFFFFF0, "R6 hi size 2^36");
    cfg_wr(6'd7, 4'hF, 32'h12345678);
    cfg_rd(6'd7, 32'h12345670, "R6 hi address");

    // R7 unused area
    cfg_wr(6'd8, 4'hF, 32'hFFFFFFFF);
    cfg_wr(6'd9, 4'hF, 32'hFFFFFFFF);
    cfg_rd(6'd8, 32'h0, "R7 unused lo");
    cfg_rd(6'd9, 32'h0, "R7 unused hi");

    // R3 bus master modes
    check(bm_t == 1'b0 && bm_m == 1'b1, "R3 fixed modes reset", {30'h0, bm_t, bm_m}, 32'h1);
    cfg_wr(6'd1, 4'b0001, 32'h00000004);
    @(negedge clk);
    check(bm == 1'b1, "R3 both-mode set", {31'h0, bm}, 32'h1);
    check(bm_t == 1'b0, "R3 target-only ignores", {31'h0, bm_t}, 32'h0);
    cfg_rd(6'd1, 32'h00000004, "R3 cmd readback");
    cfg_wr(6'd1, 4'b1110, 32'h0);
    cfg_rd(6'd1, 32'h00000004, "R8 cmd byte0 disabled");
    cfg_wr(6'd1, 4'b0001, 32'h0);
    @(negedge clk);
    check(bm == 1'b0 && bm_m == 1'b1, "R3 both clear, master holds", {30'h0, bm, bm_m}, 32'h1);

    // R9 / R10 status
    pulse_evt(6'b000001);
    check(any == 1'b1, "R10 masked-in bit0", {31'h0, any}, 32'h1);
    cfg_rd(6'd1, 32'h01000000, "R9 bit 8 set");
    cfg_wr(6'd1, 4'b1000, 32'h01000000);
    cfg_rd(6'd1, 32'h0, "R9 w1c bit 8");
    @(negedge clk);
    check(any == 1'b0, "R10 cleared", {31'h0, any}, 32'h0);
    pulse_evt(6'b000010);
    check(any == 1'b0, "R10 masked-out bit1", {31'h0, any}, 32'h0);
    cfg_rd(6'd1, 32'h08000000, "R9 bit 11 set");
    cfg_wr(6'd1, 4'b1000, 32'h0);
    cfg_rd(6'd1, 32'h08000000, "R9 write 0 keeps");
    pulse_evt(6'b100000);
    check(any == 1'b1, "R10 masked-in bit5", {31'h0, any}, 32'h1);
    // set wins over clear
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 6'd1; be = 4'b1000; wdata = 32'hFFFFFFFF; evt = 6'b100000;
    @(negedge clk);
    req = 1'b0; we = 1'b0; evt = '0;
    cfg_rd(6'd1, 32'h80000000, "R9 set wins");
    cfg_wr(6'd1, 4'hF, 32'hF9000000);
    cfg_rd(6'd1, 32'h0, "R9 all cleared");

    repeat (3) @(negedge clk);
    check(q_exp.size() == 0, "R2 pending reads", q_exp.size(), 32'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule